// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

This block runs on the source clock that drives two bank clock dividers. It is told the divide ratio of each bank: the number of source cycles in one period of that bank clock. From these two ratios it drives one active-low registered sync output. The output marks each point where a rising edge of the first bank clock lands on a rising edge of the second bank clock. Downstream logic can then align to a common phase even when the two bank frequencies are not integer multiples of each other.

After a reset or a change of ratio, the block first lets one full coincidence cycle go by. During that cycle it finds the cycle length by letting one phase counter per bank run until both wrap on the same edge. After that it repeats the cycle with one counter. It pulls the output low for one period of the faster bank clock, and the pulse ends exactly at the coincident edge. When the two ratios are equal, every edge coincides. In that case the pattern alternates: one faster-clock period low, then one high.

Top module: `coin_sync_gen`

## Requirements
- R1: While `rstN` is low at a rising clock edge, `syncN` is 1 after that edge.
- R2: Call the first rising edge after reset release, or the first edge that sees a new ratio pair, the restart edge (edge 0). With L the least common multiple of the two effective ratios, `syncN` stays 1 after edges 0 through L.
- R3: For unequal ratios, the low pulses repeat every N = L source cycles.
- R4: Each low pulse lasts exactly P source cycles, where P is the smaller effective ratio.
- R5: Let j = (e-1-L) mod N. For every edge e > L, `syncN` after edge e is 0 exactly when j >= N-P. The last low cycle therefore ends on a coincident edge.
- R6: For equal ratios, N = 2P: P cycles low, then P cycles high, repeating.
- R7: A change of either effective ratio restarts the block at the edge that first sees it: `syncN` is 1 after that edge, and R2 then applies again.
- R8: A ratio input of 0 is treated as a ratio of 1.
- R9: When one ratio is an integer multiple of the other, the pulse still repeats every max-ratio cycles with a width of P.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common source clock of both bank dividers |
| rstN | input | 1 | Synchronous active-low reset |
| divA | input | DIV_W | Divide ratio of the first bank (source cycles per bank period) |
| divC | input | DIV_W | Divide ratio of the second bank |
| syncN | output | 1 | Registered active-low sync pulse |

## Verification
The bench drives coprime ratio pairs, whose long coincidence cycles expose any error in the measured length. It drives integer-multiple pairs, where a design keyed to the slower clock would still look right, and equal pairs, which need the doubled period. It also drives ratio pairs that contain a zero, and a change of ratio mid-run without reset, which shows whether the measurement restarts. Random pairs fill the space between these cases. Every output cycle is compared with the placement formula, so a pulse that is shifted, too wide or out of period is caught.

// File: rtl/coin_sync_pkg.sv
package coin_sync_pkg;
  // strobes from control to datapath
  typedef struct packed {
    logic restart;   // reload ratios, clear counters
    logic capture;   // store measured cycle length
    logic run;       // cycle length known, pulses allowed
  } ctlStrobe_t;
endpackage

// File: rtl/coin_sync_dp.sv
module coin_sync_dp
  import coin_sync_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divC,
  input  ctlStrobe_t       stb,
  output logic             cfgChanged,
  output logic             coincide,
  output logic             syncN
);
  localparam int CNT_W = 2 * DIV_W + 1;
  localparam int NBANK = 2;
  localparam logic [DIV_W-1:0] DONE = DIV_W'(1);
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  logic [DIV_W-1:0] rawDiv [NBANK];
  logic [DIV_W-1:0] effDiv [NBANK];
  logic [DIV_W-1:0] held   [NBANK];
  logic [DIV_W-1:0] phase  [NBANK];
  logic [NBANK-1:0] bankDiff;
  logic [NBANK-1:0] bankWrap;

  assign rawDiv[0] = divA;
  assign rawDiv[1] = divC;

  for (genvar g = 0; g < NBANK; g++) begin : gBank
    assign effDiv[g]   = (rawDiv[g] == '0) ? DONE : rawDiv[g];
    assign bankDiff[g] = (effDiv[g] != held[g]);
    assign bankWrap[g] = (phase[g] == held[g] - DONE);

    always_ff @(posedge clk) begin
      if (!rstN) begin
        held[g]  <= '0;
        phase[g] <= '0;
      end else if (stb.restart) begin
        held[g]  <= effDiv[g];
        phase[g] <= '0;
      end else if (bankWrap[g]) begin
        phase[g] <= '0;
      end else begin
        phase[g] <= phase[g] + DONE;
      end
    end
  end

  assign cfgChanged = |bankDiff;
  assign coincide   = &bankWrap;

  logic [DIV_W-1:0] minDiv;
  logic [CNT_W-1:0] cnt, lenReg, measured, lenNext, lowStart;
  logic             syncQ;

  assign minDiv   = (held[0] < held[1]) ? held[0] : held[1];
  assign measured = cnt + CONE;
  assign lenNext  = (held[0] == held[1]) ? (measured << 1) : measured;
  assign lowStart = lenReg - CNT_W'(minDiv);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cnt    <= '0;
      lenReg <= '0;
      syncQ  <= 1'b1;
    end else if (stb.restart) begin
      cnt    <= '0;
      syncQ  <= 1'b1;
    end else begin
      if (stb.capture) begin
        lenReg <= lenNext;
        cnt    <= '0;
      end else if (stb.run && (cnt == lenReg - CONE)) begin
        cnt    <= '0;
      end else begin
        cnt    <= cnt + CONE;
      end
      syncQ <= !(stb.run && (cnt >= lowStart));
    end
  end

  assign syncN = syncQ;
endmodule

// File: rtl/coin_sync_ctl.sv
module coin_sync_ctl
  import coin_sync_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       cfgChanged,
  input  logic       coincide,
  output ctlStrobe_t stb
);
  typedef enum logic {ST_MEASURE, ST_RUN} state_t;
  state_t state;

  always_comb begin
    stb.restart = cfgChanged;
    stb.capture = (state == ST_MEASURE) && coincide && !cfgChanged;
    stb.run     = (state == ST_RUN) && !cfgChanged;
  end

  always_ff @(posedge clk) begin
    if (!rstN)            state <= ST_MEASURE;
    else if (stb.restart) state <= ST_MEASURE;
    else if (stb.capture) state <= ST_RUN;
  end
endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen
  import coin_sync_pkg::*;
#(
  parameter int DIV_W = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [DIV_W-1:0] divA,
  input  logic [DIV_W-1:0] divC,
  output logic             syncN
);
  ctlStrobe_t stb;
  logic       cfgChanged;
  logic       coincide;

  coin_sync_ctl u_ctl (
    .clk        (clk),
    .rstN       (rstN),
    .cfgChanged (cfgChanged),
    .coincide   (coincide),
    .stb        (stb)
  );

  coin_sync_dp #(.DIV_W(DIV_W)) u_dp (
    .clk        (clk),
    .rstN       (rstN),
    .divA       (divA),
    .divC       (divC),
    .stb        (stb),
    .cfgChanged (cfgChanged),
    .coincide   (coincide),
    .syncN      (syncN)
  );
endmodule

// File: rtl/coin_sync_chk.sv
module coin_sync_chk #(
  parameter int DIV_W = 4
) (
  input logic             clk,
  input logic             rstN,
  input logic [DIV_W-1:0] divA,
  input logic [DIV_W-1:0] divC,
  input logic             syncN
);
  localparam int CNT_W = 2 * DIV_W + 1;
  localparam logic [DIV_W-1:0] DONE = DIV_W'(1);
  localparam logic [CNT_W-1:0] CONE = CNT_W'(1);

  logic [DIV_W-1:0] aEff, cEff, minEff, minQ;
  logic [CNT_W-1:0] lowRun, highRun;
  logic             inRst;

  assign aEff   = (divA == '0) ? DONE : divA;
  assign cEff   = (divC == '0) ? DONE : divC;
  assign minEff = (aEff < cEff) ? aEff : cEff;

  always_ff @(posedge clk) begin
    inRst <= !rstN;
    if (!rstN) begin
      lowRun  <= '0;
      highRun <= '0;
      minQ    <= DONE;
    end else begin
      minQ    <= minEff;
      lowRun  <= syncN ? '0 : lowRun + CONE;
      highRun <= !syncN ? '0 : ((highRun == '1) ? highRun : highRun + CONE);
    end
  end

  // R1
  always_ff @(posedge clk) begin
    if (inRst === 1'b1) begin
      rst_high_chk: assert (syncN);
    end
  end

  // R7
  ratio_change_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rstN) && ((aEff != $past(aEff)) || (cEff != $past(cEff)))) |=> syncN);

  // R4
  low_width_chk: assert property (@(posedge clk) disable iff (!rstN)
    !syncN |-> (lowRun < CNT_W'(minQ)));

  // R3
  high_gap_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(syncN) |-> (highRun >= CNT_W'(minQ)));
endmodule

bind coin_sync_gen coin_sync_chk #(.DIV_W(DIV_W)) u_chk (
  .clk   (clk),
  .rstN  (rstN),
  .divA  (divA),
  .divC  (divC),
  .syncN (syncN)
);

// File: tb/coin_sync_gen_test.sv
`timescale 1ns/1ps
module coin_sync_gen_test;
  localparam int DIV_W = 4;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [DIV_W-1:0] divA = 4'd1;
  logic [DIV_W-1:0] divC = 4'd1;
  logic             syncN;

  int  tests = 0;
  int  fails = 0;
  bit  reported = 1'b0;

  always #2.5 clk = ~clk;

  coin_sync_gen #(.DIV_W(DIV_W)) uut (
    .clk(clk), .rstN(rstN), .divA(divA), .divC(divC), .syncN(syncN)
  );

  function automatic int gcdf(int x, int y);
    while (y != 0) begin
      int t = x % y;
      x = y;
      y = t;
    end
    return x;
  endfunction

  function automatic int effOf(int v);
    return (v == 0) ? 1 : v;
  endfunction

  task automatic check(string tag, logic expv);
    tests++;
    if (syncN !== expv) begin
      fails++;
      $display("FAIL %s: syncN=%b expected %b at %0t", tag, syncN, expv, $time);
    end
  endtask

  task automatic summary();
    if (!reported) begin
      reported = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
    end
  endtask

  // apply ratio pair, optionally through reset, and check every cycle
  task automatic runCfg(int a, int c, bit withReset, bit isChange);
    int ea = effOf(a);
    int ec = effOf(c);
    int p  = (ea < ec) ? ea : ec;
    int q  = (ea < ec) ? ec : ea;
    int l  = ea / gcdf(ea, ec) * ec;
    int n  = (ea == ec) ? 2 * l : l;
    bit zeroCase  = (a == 0) || (c == 0);
    bit ratioCase = (ea != ec) && (q % p == 0);
    @(negedge clk);
    divA = DIV_W'(a);
    divC = DIV_W'(c);
    if (withReset) begin
      rstN = 1'b0;
      for (int k = 0; k < 2; k++) begin
        @(negedge clk);
        check("R1", 1'b1);
      end
      rstN = 1'b1;
    end
    for (int e = 0; e <= l + 2 * n + 2; e++) begin
      int  j;
      logic expv;
      string tag;
      @(negedge clk);
      if (e <= l) begin
        expv = 1'b1;
        j = 0;
      end else begin
        j = (e - 1 - l) % n;
        expv = (j >= n - p) ? 1'b0 : 1'b1;
      end
      if (zeroCase)                 tag = "R8";
      else if (isChange && e <= l)  tag = "R7";
      else if (e <= l)              tag = "R2";
      else if (ea == ec)            tag = "R6";
      else if (ratioCase)           tag = "R9";
      else if (!expv && j == n - 1) tag = "R5";
      else if (!expv)               tag = "R4";
      else                          tag = "R3";
      check(tag, expv);
    end
  endtask

  initial begin
    #(5.0 * 150000);
    fails++;
    $display("FAIL watchdog: run did not end, expected completion");
    summary();
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    // reset state
    repeat (3) @(negedge clk);
    check("R1", 1'b1);
    // directed corners
    runCfg(5, 7, 1, 0);     // coprime, long cycle
    runCfg(3, 3, 1, 0);     // equal ratios
    runCfg(1, 1, 1, 0);     // equal, fastest
    runCfg(2, 8, 1, 0);     // integer multiple
    runCfg(12, 4, 1, 0);    // integer multiple, swapped
    runCfg(0, 4, 1, 0);     // zero ratio
    runCfg(6, 0, 1, 0);     // zero ratio on the other bank
    runCfg(15, 14, 1, 0);   // largest coprime pair
    runCfg(3, 9, 0, 1);     // change without reset
    runCfg(4, 6, 0, 1);     // change again
    runCfg(4, 4, 0, 1);     // change into equal
    // constrained random pairs
    for (int r = 0; r < 20; r++) begin
      int a = int'($urandom_range(1, 15));
      int c = int'($urandom_range(1, 15));
      runCfg(a, c, 1, 0);
    end
    summary();
    $finish;
  end
endmodule